// File: doc/BRIEF.md
# LCD Backplane and Segment Phase Generator

This block makes the square-wave backplane and the per-segment drive bits for a static liquid crystal display. A one-cycle enable pulse arrives once per oscillator period, whether that oscillator runs on-chip or comes in from outside. The block counts these pulses and divides their rate by 256 to form a backplane with a 50% duty cycle. Each segment bit is the backplane, inverted when that segment is lit. A segment with no inversion has no AC voltage across it and stays dark.

Which segments are lit comes from the parallel data word that the shift-register latch holds. A two-bit test input can replace that word with a forced pattern: all dark, all lit, or alternating. A supply-good flag has priority over everything else. While the flag is low, the backplane and every segment go to 0, so the display has no voltage across it. The divider is also held cleared, and the backplane restarts from 0 when the flag returns. All outputs are registered, so segment edges line up with backplane edges.

Top module: `lcd_phase_gen`

## Requirements
- R1: After reset `bp_o` and every bit of `seg_o` are 0.
- R2: With the supply good, `bp_o` changes only on a clock edge where `osc_en_i` is 1. It is 1 exactly when the number of enables counted since reset or blanking, taken modulo 256, is 128 or more. This gives one backplane period per 256 enables.
- R3: When `test_i` is 2'b00, segment i drives `~bp_o` if `seg_data_i[i]` is 1 and drives `bp_o` if it is 0. The result appears one clock after the data is sampled.
- R4: When `test_i` is 2'b01, every segment equals `bp_o` (all dark), whatever the data.
- R5: When `test_i` is 2'b10, every segment equals `~bp_o` (all lit), whatever the data.
- R6: When `test_i` is 2'b11, bits 0, 2, 4, … of `seg_o` equal `~bp_o` and bits 1, 3, 5, … equal `bp_o`. In segment numbering from 1, the odd-numbered segments are lit.
- R7: One clock after `supply_ok_i` is sampled low, `bp_o` and all of `seg_o` are 0, whatever the data, the test mode or the enable.
- R8: Blanking clears the divider. After the supply returns, `bp_o` stays 0 until 128 further enables have been counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_en_i | input | 1 | One pulse per oscillator period |
| supply_ok_i | input | 1 | Logic supply good; low blanks the display |
| test_i | input | 2 | Display mode {high, low}: 00 data, 01 dark, 10 lit, 11 alternating |
| seg_data_i | input | NUM_SEG | Latched segment data, 1 = lit |
| bp_o | output | 1 | Backplane phase |
| seg_o | output | NUM_SEG | Segment phases |

## Verification
If the divider count is wrong, the backplane edges move away from every 128th enable. The bench sees this within one half-period, at most 128 enables after the error starts. If the mode selection or the phase inversion is wrong, some segment bit disagrees with the backplane on the very next clock. Stepping through all four modes on both backplane phases therefore exposes it at once. If the divider is not cleared by blanking, the first backplane edge after the supply returns comes early.

// File: rtl/lcd_phase_pkg.sv
package lcd_phase_pkg;
  typedef enum logic [1:0] {
    MODE_DATA = 2'b00,
    MODE_DARK = 2'b01,
    MODE_LIT  = 2'b10,
    MODE_ALT  = 2'b11
  } disp_mode_e;
endpackage

// File: rtl/lcd_bp_divider.sv
module lcd_bp_divider #(
  parameter int unsigned DIV_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic bp_next_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // MSB of the count: half-period of 2**(DIV_W-1) enables
  assign bp_next_o = cnt_d[DIV_W-1];
endmodule

// File: rtl/lcd_seg_select.sv
module lcd_seg_select
  import lcd_phase_pkg::*;
#(
  parameter int unsigned NUM_SEG = 38
) (
  input  disp_mode_e         mode_i,
  input  logic [NUM_SEG-1:0] data_i,
  output logic [NUM_SEG-1:0] lit_o
);
  logic [NUM_SEG-1:0] alt_pat;

  // bit 0 is segment 1: even bit index lit
  for (genvar i = 0; i < NUM_SEG; i++) begin : g_alt
    assign alt_pat[i] = (i % 2 == 0);
  end

  always_comb begin
    unique case (mode_i)
      MODE_DATA: lit_o = data_i;
      MODE_DARK: lit_o = '0;
      MODE_LIT:  lit_o = '1;
      MODE_ALT:  lit_o = alt_pat;
      default:   lit_o = data_i;
    endcase
  end
endmodule

// File: rtl/lcd_phase_gen.sv
module lcd_phase_gen
  import lcd_phase_pkg::*;
#(
  parameter int unsigned NUM_SEG = 38,
  parameter int unsigned DIV_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               osc_en_i,
  input  logic               supply_ok_i,
  input  logic [1:0]         test_i,
  input  logic [NUM_SEG-1:0] seg_data_i,
  output logic               bp_o,
  output logic [NUM_SEG-1:0] seg_o
);
  logic               bp_next;
  logic [NUM_SEG-1:0] lit;
  logic               bp_q;
  logic [NUM_SEG-1:0] seg_q;

  lcd_bp_divider #(.DIV_W(DIV_W)) i_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!supply_ok_i),
    .en_i      (osc_en_i),
    .bp_next_o (bp_next)
  );

  lcd_seg_select #(.NUM_SEG(NUM_SEG)) i_sel (
    .mode_i (disp_mode_e'(test_i)),
    .data_i (seg_data_i),
    .lit_o  (lit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bp_q  <= 1'b0;
      seg_q <= '0;
    end else if (!supply_ok_i) begin
      bp_q  <= 1'b0;
      seg_q <= '0;
    end else begin
      bp_q  <= bp_next;
      seg_q <= lit ^ {NUM_SEG{bp_next}};
    end
  end

  assign bp_o  = bp_q;
  assign seg_o = seg_q;
endmodule

// File: rtl/lcd_phase_gen_chk.sv
module lcd_phase_gen_chk #(
  parameter int unsigned NUM_SEG = 38
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               osc_en_i,
  input logic               supply_ok_i,
  input logic [1:0]         test_i,
  input logic [NUM_SEG-1:0] seg_data_i,
  input logic               bp_o,
  input logic [NUM_SEG-1:0] seg_o
);
  function automatic logic [NUM_SEG-1:0] odd_lit();
    logic [NUM_SEG-1:0] p;
    for (int i = 0; i < NUM_SEG; i++) p[i] = ~i[0];
    return p;
  endfunction

  assert_blank_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (bp_o == 1'b0 && seg_o == '0));

  assert_bp_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supply_ok_i && !osc_en_i) |=> $stable(bp_o));

  assert_data_phase_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supply_ok_i && test_i == 2'b00) |=>
      seg_o == ($past(seg_data_i) ^ {NUM_SEG{bp_o}}));

  assert_dark_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supply_ok_i && test_i == 2'b01) |=> seg_o == {NUM_SEG{bp_o}});

  assert_lit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supply_ok_i && test_i == 2'b10) |=> seg_o == {NUM_SEG{~bp_o}});

  assert_alt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supply_ok_i && test_i == 2'b11) |=> seg_o == (odd_lit() ^ {NUM_SEG{bp_o}}));
endmodule

bind lcd_phase_gen lcd_phase_gen_chk #(.NUM_SEG(NUM_SEG)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .osc_en_i    (osc_en_i),
  .supply_ok_i (supply_ok_i),
  .test_i      (test_i),
  .seg_data_i  (seg_data_i),
  .bp_o        (bp_o),
  .seg_o       (seg_o)
);

// File: tb/test_lcd_phase_gen.sv
module test_lcd_phase_gen;
  localparam int N = 38;

  typedef struct {
    logic         bp;
    logic [N-1:0] seg;
    string        tag;
  } exp_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         osc_en_i = 1'b0;
  logic         supply_ok_i = 1'b1;
  logic [1:0]   test_i = 2'b00;
  logic [N-1:0] seg_data_i = '0;
  logic         bp_o;
  logic [N-1:0] seg_o;

  int   n_run = 0;
  int   n_fail = 0;
  int   k = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #10 clk_i = ~clk_i;

  lcd_phase_gen #(.NUM_SEG(N)) i_lcd_phase_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .osc_en_i(osc_en_i),
    .supply_ok_i(supply_ok_i), .test_i(test_i),
    .seg_data_i(seg_data_i), .bp_o(bp_o), .seg_o(seg_o));

  function automatic logic [N-1:0] lit_of(logic [1:0] m, logic [N-1:0] d);
    logic [N-1:0] p;
    for (int i = 0; i < N; i++) p[i] = (i % 2 == 0);
    case (m)
      2'b00:   return d;
      2'b01:   return '0;
      2'b10:   return '1;
      default: return p;
    endcase
  endfunction

  task automatic step(input logic [N-1:0] d, input logic [1:0] m,
                      input logic ok, input logic en, input string tag);
    exp_t e;
    @(negedge clk_i);
    seg_data_i  = d;
    test_i      = m;
    supply_ok_i = ok;
    osc_en_i    = en;
    if (!ok) k = 0;
    else if (en) k = (k + 1) % 256;
    e.bp  = ok && (k >= 128);
    e.seg = ok ? (lit_of(m, d) ^ {N{e.bp}}) : '0;
    e.tag = tag;
    q.push_back(e);
  endtask

  function automatic logic [N-1:0] rnd();
    return N'({$urandom, $urandom});
  endfunction

  // monitor: compare one expected item per clock
  always @(posedge clk_i) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (bp_o !== e.bp || seg_o !== e.seg) begin
        n_fail++;
        $display("FAIL %s bp=%b exp=%b seg=%h exp=%h", e.tag, bp_o, e.bp, seg_o, e.seg);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #5;
    n_run++;
    if (bp_o !== 1'b0 || seg_o !== '0) begin
      n_fail++;
      $display("FAIL R1 bp=%b exp=0 seg=%h exp=0", bp_o, seg_o);
    end
    #30 rst_ni = 1'b1;

    // R3: data phasing across two backplane periods, enables on most cycles
    for (int i = 0; i < 600; i++) step(rnd(), 2'b00, 1'b1, (i % 5) != 3, "R3");
    // R2: gaps without enables must not move the backplane
    for (int i = 0; i < 40; i++) step(rnd(), 2'b00, 1'b1, 1'b0, "R2");
    for (int i = 0; i < 300; i++) step(rnd(), 2'b00, 1'b1, 1'b1, "R2");
    // R4, R5, R6 over a full period each
    for (int i = 0; i < 270; i++) step(rnd(), 2'b01, 1'b1, 1'b1, "R4");
    for (int i = 0; i < 270; i++) step(rnd(), 2'b10, 1'b1, 1'b1, "R5");
    for (int i = 0; i < 270; i++) step(rnd(), 2'b11, 1'b1, 1'b1, "R6");
    // land in the high half, then blank
    while (k < 150) step(rnd(), 2'b10, 1'b1, 1'b1, "R5");
    for (int i = 0; i < 20; i++) step(rnd(), 2'(i), 1'b0, 1'b1, "R7");
    // R8: restart from zero count
    for (int i = 0; i < 300; i++) step(rnd(), 2'b11, 1'b1, 1'b1, "R8");
    // mode changes every cycle
    for (int i = 0; i < 400; i++) step(rnd(), 2'($urandom), 1'b1, 1'($urandom), "R3");
    @(negedge clk_i);
    @(negedge clk_i);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule